// File: doc/BRIEF.md
# Two-Stage Prefetch Fetch/Execute Unit

This block runs instruction fetch at the same time as execution. A fetch stage sends sequential addresses to a synchronous instruction memory. The word that comes back waits in a one-entry buffer. An execute stage takes that word only when it has no work, or when it is in the last cycle of its current instruction. Execute has no fixed latency: every instruction names its own cycle count in a field of its word. Conditional branches resolve in the last execute cycle, and a taken branch sends a redirect back to the fetch stage.

An instruction word is 16 bits wide:

| Bits | Meaning |
|------|---------|
| 15 | branch flag |
| 14 | branch outcome (1 = taken) |
| 13:12 | latency field L; the instruction spends L+1 cycles in execute |
| 11:0 | branch target address |

The memory port has one cycle of latency. The memory registers the addressed word when a request is made and holds its output until the next request. The block counts this output register as the storage of its buffer.

The `policy_i` input selects how the block handles branches:
- 0 (hold policy): fetch stops as soon as a branch is seen in the buffer or in execute.
- 1 (speculative policy): fetch keeps reading sequential addresses and throws away the wrong-path word when a branch is taken.

Two counters let the branch penalty be measured from outside the block:
- retired instructions;
- cycles in which execute held no instruction.

Top module: `fx_prefetch_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the block shows:
  - `retire_o` and `redirect_o` low;
  - both counters at zero.

  In that first cycle it issues a fetch of address 0.
- R2: A fetch is issued only when the buffer is empty or is handing its word to execute in that cycle. Each issued fetch that is not followed by a redirect advances the fetch address by one.
- R3: The buffered word enters execute only when execute is idle or in the final cycle of its current instruction. A word fetched in cycle t can therefore enter execute at the earliest in cycle t+1 and begin executing in t+2.
- R4: An instruction with latency field L (bits 13:12) occupies execute for exactly L+1 cycles. `retire_o` pulses in the last of those cycles, and `retire_pc_o` carries the instruction's address.
- R5: A branch (bit 15 set) with bit 14 set asserts `redirect_o` in its retire cycle, and `redirect_pc_o` equals bits 11:0. A branch with bit 14 clear never redirects.
- R6: In a redirect cycle the buffer is cleared and no fetch is issued. A word discarded this way never retires.
- R7: In the cycle after a redirect, a fetch of the branch target is issued.
- R8: Under the hold policy, no fetch is issued while a branch is in the buffer or in execute. A branch with L=0 in a stream of L=0 instructions therefore costs two idle execute cycles, whether or not it is taken.
- R9: Under the speculative policy, fetch continues sequentially past an unresolved branch:
  - a not-taken branch with L=0 costs no idle execute cycle;
  - a taken one costs two idle execute cycles.
- R10: `instr_count_o` increases by one in the cycle after each `retire_o` pulse, and at no other time.
- R11: `idle_count_o` counts every cycle since reset in which execute held no instruction. It shows the total up to the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| policy_i | input | 1 | Branch policy: 0 hold, 1 speculative |
| imem_req_o | output | 1 | Instruction memory read request |
| imem_addr_o | output | 12 | Instruction memory word address |
| imem_data_i | input | 16 | Memory output word, valid the cycle after a request and held until the next request |
| retire_o | output | 1 | Instruction completes this cycle |
| retire_pc_o | output | 12 | Address of the completing instruction (meaningful when `retire_o` is high) |
| redirect_o | output | 1 | Taken branch resolved this cycle |
| redirect_pc_o | output | 12 | Branch target (meaningful when `redirect_o` is high) |
| instr_count_o | output | 16 | Retired instruction count |
| idle_count_o | output | 16 | Execute idle cycle count |

## Verification
The hardest case to reach is a taken branch under the speculative policy when a wrong-path word already sits in the buffer. The flush and the redirect must happen in the same cycle as the branch's last execute cycle, and the fetch must be suppressed in that cycle. The stimulus reaches this case with a program in which a taken branch follows two single-cycle instructions. It then confirms at the ports that the discarded address was requested but never retired. Programs with mixed latencies and pseudo-random branches are run under both policies against a cycle-level reference model, so that back-to-back handoffs at the end of a long instruction also occur.

// File: rtl/fx_pkg.sv
`timescale 1ns/1ps
package fx_pkg;
    localparam int unsigned IW      = 16;
    localparam int unsigned LATW    = 2;
    localparam int unsigned PCW     = IW - 2 - LATW;
    localparam int unsigned CNTW    = 16;
    localparam int unsigned BR_BIT  = IW - 1;
    localparam int unsigned TK_BIT  = IW - 2;
    localparam int unsigned LAT_LSB = PCW;

    typedef logic [IW-1:0]   word_t;
    typedef logic [PCW-1:0]  pc_t;
    typedef logic [LATW-1:0] lat_t;
    typedef logic [CNTW-1:0] cnt_t;

    localparam pc_t RESET_PC = '0;

    typedef enum logic {
        POL_HOLD = 1'b0,
        POL_SPEC = 1'b1
    } policy_e;

    typedef struct packed {
        logic is_br;
        logic taken;
        lat_t lat;
        pc_t  target;
    } dec_t;

    function automatic dec_t decode(word_t w);
        dec_t d;
        d.is_br  = w[BR_BIT];
        d.taken  = w[TK_BIT];
        d.lat    = w[LAT_LSB +: LATW];
        d.target = w[PCW-1:0];
        return d;
    endfunction
endpackage

// File: rtl/fx_fetch.sv
`timescale 1ns/1ps
module fx_fetch
    import fx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  policy_e policy_i,
    input  logic    buf_is_br_i,
    input  logic    ex_br_busy_i,
    input  logic    take_i,
    input  logic    redirect_i,
    input  pc_t     redir_pc_i,
    output logic    issue_o,
    output pc_t     addr_o,
    output logic    buf_valid_o,
    output pc_t     buf_pc_o
);
    pc_t  pc_q;
    pc_t  buf_pc_q;
    logic buf_valid_q;
    logic hold;

    always_comb begin
        hold = (policy_i == POL_HOLD) &&
               ((buf_valid_q && buf_is_br_i) || ex_br_busy_i);
        issue_o = !rst && !redirect_i && !hold && (!buf_valid_q || take_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q        <= RESET_PC;
            buf_pc_q    <= '0;
            buf_valid_q <= 1'b0;
        end else if (redirect_i) begin
            pc_q        <= redir_pc_i;
            buf_valid_q <= 1'b0;
        end else if (issue_o) begin
            pc_q        <= pc_q + 1'b1;
            buf_pc_q    <= pc_q;
            buf_valid_q <= 1'b1;
        end else if (take_i) begin
            buf_valid_q <= 1'b0;
        end
    end

    assign addr_o      = pc_q;
    assign buf_valid_o = buf_valid_q;
    assign buf_pc_o    = buf_pc_q;

    // R2
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        issue_o |=> buf_valid_q);

    // R2
    seq_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(issue_o) && !$past(redirect_i) && issue_o) |-> (addr_o == $past(addr_o) + 1'b1));

    // R7
    redir_target_chk: assert property (@(posedge clk) disable iff (rst)
        redirect_i |=> (issue_o && addr_o == $past(redir_pc_i)));
endmodule

// File: rtl/fx_exec.sv
`timescale 1ns/1ps
module fx_exec
    import fx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  buf_valid_i,
    input  word_t buf_word_i,
    input  pc_t   buf_pc_i,
    output logic  take_o,
    output logic  retire_o,
    output pc_t   retire_pc_o,
    output logic  redirect_o,
    output pc_t   redir_pc_o,
    output logic  br_busy_o,
    output logic  busy_o
);
    dec_t bd;
    logic ex_v_q;
    logic ex_br_q;
    logic ex_tk_q;
    pc_t  ex_tgt_q;
    pc_t  ex_pc_q;
    lat_t left_q;
    logic last;

    always_comb begin
        bd         = decode(buf_word_i);
        last       = ex_v_q && (left_q == '0);
        retire_o   = last;
        redirect_o = last && ex_br_q && ex_tk_q;
        take_o     = buf_valid_i && (!ex_v_q || left_q == '0) && !redirect_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ex_v_q   <= 1'b0;
            ex_br_q  <= 1'b0;
            ex_tk_q  <= 1'b0;
            ex_tgt_q <= '0;
            ex_pc_q  <= '0;
            left_q   <= '0;
        end else if (take_o) begin
            ex_v_q   <= 1'b1;
            ex_br_q  <= bd.is_br;
            ex_tk_q  <= bd.taken;
            ex_tgt_q <= bd.target;
            ex_pc_q  <= buf_pc_i;
            left_q   <= bd.lat;
        end else if (last) begin
            ex_v_q <= 1'b0;
        end else if (ex_v_q) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign retire_pc_o = ex_pc_q;
    assign redir_pc_o  = ex_tgt_q;
    assign br_busy_o   = ex_v_q && ex_br_q;
    assign busy_o      = ex_v_q;

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_v_q && left_q != '0) |=> (ex_v_q && $stable(ex_pc_q)));

    // R4
    countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_v_q && left_q != '0) |=> (left_q == $past(left_q) - 1'b1));
endmodule

// File: rtl/fx_perf.sv
`timescale 1ns/1ps
module fx_perf
    import fx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic retire_i,
    input  logic busy_i,
    output cnt_t instr_count_o,
    output cnt_t idle_count_o
);
    cnt_t ic_q;
    cnt_t idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ic_q   <= '0;
            idle_q <= '0;
        end else begin
            if (retire_i) ic_q   <= ic_q + 1'b1;
            if (!busy_i)  idle_q <= idle_q + 1'b1;
        end
    end

    assign instr_count_o = ic_q;
    assign idle_count_o  = idle_q;

    // R10
    instr_inc_chk: assert property (@(posedge clk) disable iff (rst)
        retire_i |=> (instr_count_o == $past(instr_count_o) + 1'b1));

    // R10
    instr_still_chk: assert property (@(posedge clk) disable iff (rst)
        !retire_i |=> $stable(instr_count_o));
endmodule

// File: rtl/fx_prefetch_unit.sv
`timescale 1ns/1ps
module fx_prefetch_unit
    import fx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        policy_i,
    output logic        imem_req_o,
    output logic [11:0] imem_addr_o,
    input  logic [15:0] imem_data_i,
    output logic        retire_o,
    output logic [11:0] retire_pc_o,
    output logic        redirect_o,
    output logic [11:0] redirect_pc_o,
    output logic [15:0] instr_count_o,
    output logic [15:0] idle_count_o
);
    policy_e pol;
    logic    take;
    logic    buf_valid;
    pc_t     buf_pc;
    logic    ex_br_busy;
    logic    ex_busy;
    logic    redir;
    pc_t     redir_pc;
    logic    buf_is_br;

    assign pol       = policy_e'(policy_i);
    assign buf_is_br = imem_data_i[BR_BIT];

    fx_fetch u_fetch (
        .clk         (clk),
        .rst         (rst),
        .policy_i    (pol),
        .buf_is_br_i (buf_is_br),
        .ex_br_busy_i(ex_br_busy),
        .take_i      (take),
        .redirect_i  (redir),
        .redir_pc_i  (redir_pc),
        .issue_o     (imem_req_o),
        .addr_o      (imem_addr_o),
        .buf_valid_o (buf_valid),
        .buf_pc_o    (buf_pc)
    );

    fx_exec u_exec (
        .clk        (clk),
        .rst        (rst),
        .buf_valid_i(buf_valid),
        .buf_word_i (imem_data_i),
        .buf_pc_i   (buf_pc),
        .take_o     (take),
        .retire_o   (retire_o),
        .retire_pc_o(retire_pc_o),
        .redirect_o (redir),
        .redir_pc_o (redir_pc),
        .br_busy_o  (ex_br_busy),
        .busy_o     (ex_busy)
    );

    fx_perf u_perf (
        .clk          (clk),
        .rst          (rst),
        .retire_i     (retire_o),
        .busy_i       (ex_busy),
        .instr_count_o(instr_count_o),
        .idle_count_o (idle_count_o)
    );

    assign redirect_o    = redir;
    assign redirect_pc_o = redir_pc;

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (rst)
        redir |=> !buf_valid);

    // R8
    hold_nowrong_chk: assert property (@(posedge clk) disable iff (rst)
        (pol == POL_HOLD && $past(pol) == POL_HOLD && $past(take && buf_is_br)) |-> !buf_valid);
endmodule

// File: tb/fx_prefetch_unit_bench.sv
`timescale 1ns/1ps
module fx_prefetch_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        policy = 1'b0;
    logic        imem_req;
    logic [11:0] imem_addr;
    logic [15:0] imem_data = 16'h0;
    logic        retire;
    logic [11:0] retire_pc;
    logic        redirect;
    logic [11:0] redirect_pc;
    logic [15:0] instr_count;
    logic [15:0] idle_count;

    int n_chk = 0;
    int n_err = 0;
    int scen  = 0;
    bit done  = 0;

    // model state
    int m_pc, m_bpc, m_epc, m_left, m_ic, m_idle;
    bit m_bv, m_ev;
    bit saw_req3, saw_ret3;

    always #2 clk = ~clk;

    fx_prefetch_unit u_fx_prefetch_unit (
        .clk(clk), .rst(rst), .policy_i(policy),
        .imem_req_o(imem_req), .imem_addr_o(imem_addr), .imem_data_i(imem_data),
        .retire_o(retire), .retire_pc_o(retire_pc),
        .redirect_o(redirect), .redirect_pc_o(redirect_pc),
        .instr_count_o(instr_count), .idle_count_o(idle_count)
    );

    function automatic logic [15:0] prog(int sc, int a);
        int h;
        case (sc)
            0: return 16'h0000;
            1: return (a == 2) ? {1'b1, 1'b0, 2'd0, 12'd10} : 16'h0000;
            2: return (a == 2) ? {1'b1, 1'b1, 2'd0, 12'd10} : 16'h0000;
            default: begin
                h = (a * 37 + 11) % 97;
                return {1'b0 + ((h % 5) == 0), 1'b0 + (((h / 3) % 2) == 1),
                        2'(h % 4), 12'((h * 7) % 64)};
            end
        endcase
    endfunction

    always @(posedge clk) if (imem_req) imem_data <= prog(scen, int'(imem_addr));

    task automatic chk(input string rq, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic model_reset();
        m_pc = 0; m_bpc = 0; m_epc = 0; m_left = 0; m_ic = 0; m_idle = 0;
        m_bv = 0; m_ev = 0; saw_req3 = 0; saw_ret3 = 0;
    endtask

    task automatic step();
        logic [15:0] bw, ew;
        bit fin, redir, take, hold, iss;
        bw    = prog(scen, m_bpc);
        ew    = prog(scen, m_epc);
        fin   = m_ev && m_left == 0;
        redir = fin && ew[15] && ew[14];
        take  = m_bv && (!m_ev || m_left == 0) && !redir;
        hold  = (policy == 1'b0) && ((m_bv && bw[15]) || (m_ev && ew[15]));
        iss   = !redir && !hold && (!m_bv || take);
        // compare
        chk("R2 req", imem_req, iss);
        if (iss) chk("R2/R7 addr", imem_addr, m_pc);
        chk("R3/R4 retire", retire, fin);
        if (fin) chk("R4 retire_pc", retire_pc, m_epc);
        chk("R5/R6 redirect", redirect, redir);
        if (redir) chk("R5 target", redirect_pc, ew[11:0]);
        chk("R10 instr_count", instr_count, m_ic);
        chk("R11 idle_count", idle_count, m_idle);
        if (imem_req && imem_addr == 12'd3) saw_req3 = 1;
        if (retire && retire_pc == 12'd3) saw_ret3 = 1;
        // advance model
        m_ic   += fin;
        m_idle += !m_ev;
        if (take) begin
            m_ev = 1; m_epc = m_bpc; m_left = int'(bw[13:12]);
        end else if (fin) m_ev = 0;
        else if (m_ev) m_left--;
        if (redir) begin
            m_pc = int'(ew[11:0]); m_bv = 0;
        end else if (iss) begin
            m_bpc = m_pc; m_pc = (m_pc + 1) % 4096; m_bv = 1;
        end else if (take) m_bv = 0;
    endtask

    task automatic run(input int sc, input bit pol, input int ncyc, input bit rchk);
        rst = 1; scen = sc; policy = pol;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 while reset held
        if (rchk) begin
            chk("R1 retire in reset", retire, 0);
            chk("R1 redirect in reset", redirect, 0);
        end
        rst = 0;
        model_reset();
        #1;
        if (rchk) begin
            chk("R1 instr_count", instr_count, 0);
            chk("R1 idle_count", idle_count, 0);
            chk("R1 first req", imem_req, 1);
            chk("R1 first addr", imem_addr, 0);
        end
        step();
        for (int i = 0; i < ncyc; i++) begin
            @(negedge clk);
            step();
        end
    endtask

    initial begin
        run(0, 1'b0, 40, 1'b1);
        chk("R11 straight-line idle", idle_count, 2);
        run(1, 1'b0, 40, 1'b0);
        chk("R8 hold not-taken idle", idle_count, 4);
        run(1, 1'b1, 40, 1'b0);
        chk("R9 spec not-taken idle", idle_count, 2);
        run(2, 1'b1, 40, 1'b0);
        chk("R9 spec taken idle", idle_count, 4);
        chk("R6 wrong-path fetched", saw_req3, 1);
        chk("R6 wrong-path retired", saw_ret3, 0);
        run(2, 1'b0, 40, 1'b0);
        chk("R8 hold taken idle", idle_count, 4);
        chk("R8 no wrong-path fetch", saw_req3, 0);
        run(3, 1'b0, 600, 1'b0);
        run(3, 1'b1, 600, 1'b0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule